// File: doc/BRIEF.md
# Barrel Thread Issue Scheduler

This block decides, on every core clock, which of up to eight hardware threads may place its next instruction into a shared four-stage pipeline. A thread that is marked ready and is not paused becomes a candidate once its previous instruction has moved far enough down the pipeline. The scheduler grants candidates in strict round-robin order, so consecutive slots normally carry different threads. Each thread keeps its own architectural state, so a switch from one thread to another costs no cycles.

Because a thread may hold only one instruction in the pipeline at a time, every thread issues at most once every four clocks. With four or fewer runnable threads, each thread keeps that fixed rate and the spare slots become bubbles. With five to eight runnable threads, the rotation grows and each thread issues once every N clocks. A per-thread counter records issued instructions. A separate detector watches resource accesses reported by the execute side. It raises an exception when one thread touches a resource that a different thread used within the previous four clocks. Decode and execution are outside this block, and a stage model that carries only thread IDs stands in for the pipeline.

Top module: `barrel_sched`

## Requirements
- R1: While rst_n is low and on the first clock after it is released, issue_valid and conflict_exc are 0 and every issue counter reads 0.
- R2: A thread is never issued twice within PIPE_DEPTH (4) clocks.
- R3: Only a thread k whose thr_ready bit k is 1 and whose thr_pause bit k is 0 is issued. When no thread qualifies, issue_valid stays 0.
- R4: With 1 to 4 qualifying threads 0..n-1, each of them issues exactly once every 4 clocks, and the other slots are bubbles.
- R5: With n qualifying threads, n from 5 to 8, each of them issues exactly once every n clocks, with no bubbles.
- R6: Each grant goes to the first qualifying thread after the last granted one in ascending ID order, wrapping from 7 to 0. After reset the search starts at thread 0.
- R7: A paused thread that is released rejoins at its ID position in the rotation. The order of the other threads is unchanged, and the rejoined thread issues again.
- R8: The counter for thread k, bits [k*CNT_W +: CNT_W] of issue_count, increases by 1 on the same clock edge that shows thread k on issue_tid. It wraps modulo 2^CNT_W and holds its value otherwise.
- R9: An access by thread B to resource r raises conflict_exc on the next clock, with conflict_tid = B, when a different thread accessed r 1 to 4 clocks earlier. No exception is raised when the earlier access is 5 or more clocks earlier, comes from the same thread, or targets a different resource.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_ready | input | N_THR | Bit k: thread k has work |
| thr_pause | input | N_THR | Bit k: thread k is held out of the rotation |
| acc_valid | input | 1 | A resource access is reported this clock |
| acc_tid | input | TID_W | Thread making the access |
| acc_res | input | RES_W | Resource identifier of the access |
| issue_valid | output | 1 | A thread occupies the current issue slot |
| issue_tid | output | TID_W | Thread in the current issue slot |
| issue_count | output | N_THR*CNT_W | Per-thread issue counters, thread k at [k*CNT_W +: CNT_W] |
| conflict_exc | output | 1 | Resource-dependency exception |
| conflict_tid | output | TID_W | Thread that caused the exception |

## Verification
The bench builds the block with eight threads, a four-stage pipeline, three-bit resource IDs and six-bit counters. With six-bit counters, the wrap at 64 issues can be reached within a few hundred clocks. With eight threads, every runnable-thread count from 1 to 8 can be swept, which covers both the fixed four-clock cadence and the stretched N-clock cadence. With three-bit resource IDs, same-resource and different-resource accesses can be compared across gaps of 1 to 6 clocks, on both sides of the four-clock window.

// File: rtl/barrel_pkg.sv
`timescale 1ns/1ps
package barrel_pkg;

  // Width of a thread identifier; never below one bit.
  function automatic int unsigned id_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Position reached by stepping hop places past base on a ring of n.
  function automatic int unsigned ring_step(int unsigned base, int unsigned hop, int unsigned n);
    return (base + hop) % n;
  endfunction

endpackage

// File: rtl/thr_rr_arbiter.sv
`timescale 1ns/1ps
module thr_rr_arbiter import barrel_pkg::*; #(
  parameter int N_THR = 8,
  parameter int TID_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_THR-1:0] elig,
  output logic             grant_valid,
  output logic [TID_W-1:0] grant_tid
);

  logic [TID_W-1:0] last_q;

  // Search the ring starting one place after the previous grant.
  always_comb begin
    grant_valid = 1'b0;
    grant_tid   = '0;
    for (int k = 1; k <= N_THR; k++) begin
      if (!grant_valid && elig[TID_W'(ring_step(32'(last_q), 32'(k), N_THR))]) begin
        grant_valid = 1'b1;
        grant_tid   = TID_W'(ring_step(32'(last_q), 32'(k), N_THR));
      end
    end
  end

  // A bubble leaves the pointer where it was.
  always_ff @(posedge clk) begin
    if (!rst_n)           last_q <= TID_W'(N_THR - 1);
    else if (grant_valid) last_q <= grant_tid;
  end

endmodule

// File: rtl/thr_pipe_stub.sv
`timescale 1ns/1ps
module thr_pipe_stub #(
  parameter int N_THR = 8,
  parameter int TID_W = 3,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TID_W-1:0] in_tid,
  output logic [N_THR-1:0] busy_mask,
  output logic             slot_valid,
  output logic [TID_W-1:0] slot_tid
);

  logic [DEPTH-1:0]            stg_v;
  logic [DEPTH-1:0][TID_W-1:0] stg_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v <= '0;
      stg_t <= '0;
    end else begin
      stg_v <= {stg_v[DEPTH-2:0], in_valid};
      stg_t <= {stg_t[DEPTH-2:0], in_tid};
    end
  end

  // Threads in the first DEPTH-1 stages cannot issue. A thread in the last
  // stage is free, because it leaves that stage on the same edge.
  always_comb begin
    busy_mask = '0;
    for (int s = 0; s < DEPTH - 1; s++) begin
      if (stg_v[s]) busy_mask[stg_t[s]] = 1'b1;
    end
  end

  assign slot_valid = stg_v[0];
  assign slot_tid   = stg_t[0];

  for (genvar s = 1; s < DEPTH; s++) begin : g_flight
    // R2
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stg_v[0] && stg_v[s]) |-> (stg_t[0] != stg_t[s]));
  end

endmodule

// File: rtl/thr_issue_ctr.sv
`timescale 1ns/1ps
module thr_issue_ctr #(
  parameter int N_THR = 8,
  parameter int TID_W = 3,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inc_valid,
  input  logic [TID_W-1:0]       inc_tid,
  output logic [N_THR*CNT_W-1:0] cnt_flat
);

  for (genvar t = 0; t < N_THR; t++) begin : g_ctr
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                    c_q <= '0;
      else if (inc_valid && (inc_tid == TID_W'(t)))  c_q <= c_q + 1'b1;
    end
    assign cnt_flat[t*CNT_W +: CNT_W] = c_q;
  end

endmodule

// File: rtl/res_conflict_det.sv
`timescale 1ns/1ps
module res_conflict_det #(
  parameter int TID_W = 3,
  parameter int RES_W = 4,
  parameter int WIN   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [TID_W-1:0] acc_tid,
  input  logic [RES_W-1:0] acc_res,
  output logic             exc,
  output logic [TID_W-1:0] exc_tid
);

  logic [WIN-1:0]            hist_v;
  logic [WIN-1:0][TID_W-1:0] hist_t;
  logic [WIN-1:0][RES_W-1:0] hist_r;
  logic                      clash;

  // A same-resource, other-thread access within the last WIN clocks is a clash.
  always_comb begin
    clash = 1'b0;
    for (int s = 0; s < WIN; s++) begin
      if (acc_valid && hist_v[s] && (hist_r[s] == acc_res) && (hist_t[s] != acc_tid))
        clash = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_v  <= '0;
      hist_t  <= '0;
      hist_r  <= '0;
      exc     <= 1'b0;
      exc_tid <= '0;
    end else begin
      hist_v  <= {hist_v[WIN-2:0], acc_valid};
      hist_t  <= {hist_t[WIN-2:0], acc_tid};
      hist_r  <= {hist_r[WIN-2:0], acc_res};
      exc     <= clash;
      exc_tid <= clash ? acc_tid : exc_tid;
    end
  end

  // R9
  exc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> ($past(acc_valid) && (exc_tid == $past(acc_tid))));

endmodule

// File: rtl/barrel_sched.sv
`timescale 1ns/1ps
module barrel_sched import barrel_pkg::*; #(
  parameter  int N_THR      = 8,
  parameter  int PIPE_DEPTH = 4,
  parameter  int CNT_W      = 16,
  parameter  int RES_W      = 4,
  localparam int TID_W      = id_width(N_THR)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_THR-1:0]       thr_ready,
  input  logic [N_THR-1:0]       thr_pause,
  input  logic                   acc_valid,
  input  logic [TID_W-1:0]       acc_tid,
  input  logic [RES_W-1:0]       acc_res,
  output logic                   issue_valid,
  output logic [TID_W-1:0]       issue_tid,
  output logic [N_THR*CNT_W-1:0] issue_count,
  output logic                   conflict_exc,
  output logic [TID_W-1:0]       conflict_tid
);

  logic [N_THR-1:0] want;
  logic [N_THR-1:0] busy_mask;
  logic [N_THR-1:0] elig;
  logic             grant_valid;
  logic [TID_W-1:0] grant_tid;

  assign want = thr_ready & ~thr_pause;
  assign elig = want & ~busy_mask;

  thr_rr_arbiter #(.N_THR(N_THR), .TID_W(TID_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig),
    .grant_valid(grant_valid), .grant_tid(grant_tid)
  );

  thr_pipe_stub #(.N_THR(N_THR), .TID_W(TID_W), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(grant_valid), .in_tid(grant_tid),
    .busy_mask(busy_mask), .slot_valid(issue_valid), .slot_tid(issue_tid)
  );

  thr_issue_ctr #(.N_THR(N_THR), .TID_W(TID_W), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc_valid(grant_valid), .inc_tid(grant_tid),
    .cnt_flat(issue_count)
  );

  res_conflict_det #(.TID_W(TID_W), .RES_W(RES_W), .WIN(PIPE_DEPTH)) u_conf (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_tid(acc_tid),
    .acc_res(acc_res), .exc(conflict_exc), .exc_tid(conflict_tid)
  );

  // Checker state: input request mask and counters one clock back.
  logic [N_THR-1:0]       want_d;
  logic [N_THR*CNT_W-1:0] cnt_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_d <= '0;
      cnt_d  <= '0;
    end else begin
      want_d <= want;
      cnt_d  <= issue_count;
    end
  end

  // R3
  grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> want_d[issue_tid]);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (issue_count[issue_tid*CNT_W +: CNT_W] ==
                     CNT_W'(cnt_d[issue_tid*CNT_W +: CNT_W] + 1'b1)));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (issue_count == cnt_d));

endmodule

// File: tb/tb_barrel_sched.sv
`timescale 1ns/1ps
module tb_barrel_sched;

  localparam int NT = 8;
  localparam int CW = 6;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] thr_ready = '0;
  logic [NT-1:0] thr_pause = '0;
  logic          acc_valid = 1'b0;
  logic [2:0]    acc_tid = '0;
  logic [RW-1:0] acc_res = '0;
  logic          issue_valid;
  logic [2:0]    issue_tid;
  logic [NT*CW-1:0] issue_count;
  logic          conflict_exc;
  logic [2:0]    conflict_tid;

  barrel_sched #(.N_THR(NT), .PIPE_DEPTH(4), .CNT_W(CW), .RES_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .thr_pause(thr_pause),
    .acc_valid(acc_valid), .acc_tid(acc_tid), .acc_res(acc_res),
    .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_count(issue_count),
    .conflict_exc(conflict_exc), .conflict_tid(conflict_tid)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nis[NT], lastc[NT], mn[NT], mx[NT], exp_cnt[NT];
  bit seen[NT];
  int total0 = 0;
  int prev = -1;
  int mt, iv;
  bit rr_on = 1'b0;
  int rr_n = 0, rr_bad = 0;
  logic [NT-1:0] s_edge = '0;

  always @(posedge clk) s_edge <= thr_ready & ~thr_pause;

  function automatic int succ(int p, logic [NT-1:0] s);
    for (int k = 1; k <= NT; k++) if (s[(p + k) % NT]) return (p + k) % NT;
    return -1;
  endfunction

  initial for (int t = 0; t < NT; t++) begin
    exp_cnt[t] = 0; nis[t] = 0; seen[t] = 0; mn[t] = 1000; mx[t] = 0; lastc[t] = 0;
  end

  // Observer: issue times, intervals, order and the expected counter values.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && issue_valid) begin
      mt = int'(issue_tid);
      exp_cnt[mt] = (exp_cnt[mt] + 1) % (1 << CW);
      if (mt == 0) total0++;
      nis[mt]++;
      if (seen[mt]) begin
        iv = cyc - lastc[mt];
        if (iv < mn[mt]) mn[mt] = iv;
        if (iv > mx[mt]) mx[mt] = iv;
      end
      seen[mt] = 1'b1;
      lastc[mt] = cyc;
      if (rr_on && prev >= 0) begin
        rr_n++;
        if (mt != succ(prev, s_edge)) rr_bad++;
      end
      prev = mt;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_stats();
    for (int t = 0; t < NT; t++) begin
      nis[t] = 0; seen[t] = 0; mn[t] = 1000; mx[t] = 0;
    end
    rr_n = 0; rr_bad = 0;
  endtask

  task automatic check_counts(string req);
    for (int t = 0; t < NT; t++)
      chk(int'(issue_count[t*CW +: CW]) == exp_cnt[t], req, $sformatf("count thread %0d", t),
          int'(issue_count[t*CW +: CW]), exp_cnt[t]);
  endtask

  task automatic test_reset();
    thr_ready = '1;
    repeat (3) step();
    chk(issue_valid == 1'b0, "R1", "issue_valid in reset", int'(issue_valid), 0);
    chk(conflict_exc == 1'b0, "R1", "conflict_exc in reset", int'(conflict_exc), 0);
    chk(issue_count == '0, "R1", "counters in reset", int'(issue_count != '0), 0);
    thr_ready = '0;
    rst_n = 1'b1;
    step();
    chk(issue_valid == 1'b0, "R1", "issue_valid after release", int'(issue_valid), 0);
  endtask

  // n runnable threads 0..n-1: fixed interval and ring order.
  task automatic test_group(int n);
    int expv;
    string req;
    expv = (n > 4) ? n : 4;
    req = (n > 4) ? "R5" : "R4";
    thr_pause = '0;
    thr_ready = NT'((1 << n) - 1);
    repeat (20) step();
    clear_stats();
    rr_on = 1'b1;
    repeat (48) step();
    rr_on = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (t < n)
        chk(nis[t] >= 2 && mn[t] == expv && mx[t] == expv, req,
            $sformatf("n=%0d thread %0d interval", n, t), mx[t], expv);
      else
        chk(nis[t] == 0, "R3", $sformatf("n=%0d idle thread %0d issues", n, t), nis[t], 0);
    end
    chk(rr_bad == 0 && rr_n > 0, "R6", $sformatf("n=%0d order mismatches", n), rr_bad, 0);
  endtask

  task automatic test_bubble();
    thr_ready = '0;
    thr_pause = '0;
    repeat (8) step();
    clear_stats();
    repeat (10) step();
    chk(nis.sum() == 0, "R3", "issues with nothing ready", nis.sum(), 0);
    chk(issue_valid == 1'b0, "R3", "issue_valid with nothing ready", int'(issue_valid), 0);
  endtask

  task automatic test_pause_rejoin();
    thr_ready = '1;
    thr_pause = 8'b0010_0100;
    repeat (20) step();
    clear_stats();
    rr_on = 1'b1;
    repeat (48) step();
    chk(nis[2] == 0 && nis[5] == 0, "R3", "paused threads issued", nis[2] + nis[5], 0);
    chk(mn[0] == 6 && mx[0] == 6, "R5", "interval with six runnable", mx[0], 6);
    chk(rr_bad == 0, "R6", "order with paused threads", rr_bad, 0);
    clear_stats();
    thr_pause = 8'b0010_0000;
    repeat (24) step();
    chk(rr_bad == 0 && rr_n > 0, "R7", "order across rejoin", rr_bad, 0);
    chk(nis[2] > 0, "R7", "rejoined thread issues", nis[2], 1);
    clear_stats();
    repeat (42) step();
    rr_on = 1'b0;
    chk(mn[2] == 7 && mx[2] == 7 && mn[7] == 7 && mx[7] == 7, "R7",
        "interval after rejoin", mx[2], 7);
    thr_pause = '0;
  endtask

  task automatic test_counts();
    thr_ready = 8'b0000_0001;
    repeat (300) step();
    chk(total0 >= (1 << CW), "R8", "thread 0 issues past wrap", total0, 1 << CW);
    check_counts("R8");
    thr_ready = '0;
    repeat (6) step();
    check_counts("R8");
  endtask

  task automatic conf_case(string what, int a_t, int a_r, int b_t, int b_r, int d, bit expv);
    acc_valid = 1'b0;
    repeat (8) step();
    acc_valid = 1'b1; acc_tid = 3'(a_t); acc_res = RW'(a_r);
    step();
    acc_valid = 1'b0;
    chk(conflict_exc == 1'b0, "R9", {what, " first access alone"}, int'(conflict_exc), 0);
    repeat (d - 1) step();
    acc_valid = 1'b1; acc_tid = 3'(b_t); acc_res = RW'(b_r);
    step();
    acc_valid = 1'b0;
    chk(conflict_exc == expv, "R9", $sformatf("%s gap %0d", what, d), int'(conflict_exc), int'(expv));
    if (expv)
      chk(int'(conflict_tid) == b_t, "R9", "conflict thread", int'(conflict_tid), b_t);
  endtask

  task automatic test_conflict();
    thr_ready = '0;
    for (int d = 1; d <= 6; d++)
      conf_case("other thread same resource", 1, 3, 6, 3, d, d <= 4);
    conf_case("same thread same resource", 4, 2, 4, 2, 2, 1'b0);
    conf_case("other thread other resource", 0, 5, 2, 1, 1, 1'b0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    for (int n = 1; n <= NT; n++) test_group(n);
    test_bubble();
    test_pause_rejoin();
    test_counts();
    test_conflict();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule